// File: doc/BRIEF.md
# Flash Programming Sequencer

This block sits on the host side of a byte-wide parallel flash bus. A client hands it one request at a time: program a byte, erase the whole chip, or permanently lock the low boot region. The engine plays out the unlock write sequence that the flash expects for that request, one bus cycle at a time. It then keeps reading the flash until the part reports that its internal operation has finished. It finishes with a one-cycle completion pulse and two outcome flags.

Every bus cycle uses a programmable number of setup, strobe-low and hold clocks. Address and write data stay fixed for the whole cycle. For a byte program, completion is detected by data polling: the top data bit read back from the target address has to equal the top bit that was written. For erase and lock, completion is detected by toggle polling: bit 6 has to read the same in two reads in a row. A read budget bounds the polling, and if it runs out the timeout flag is raised.

Top module: `flash_prog_engine`

## Requirements
- R1: Operation code 00 (byte program) issues exactly four write cycles: 5555h/AAh, 2AAAh/55h, 5555h/A0h, then the request address with the request data.
- R2: Operation code 01 (chip erase) issues exactly six write cycles: 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h, 5555h/10h.
- R3: Operation codes 10 and 11 (boot lock) issue the same six writes as R2, except that the last data byte is 40h.
- R4: During a write strobe, CE and WE are low, OE is high and the data drive enable is high. The strobe lasts exactly STROBE_CLK clocks. Address and write data do not change while CE is low. WE and OE are never low together.
- R5: During a read strobe, CE and OE are low, WE is high and the data drive enable is low.
- R6: After a program, the engine reads the request address until bit 7 of the read data equals bit 7 of the request data. The read that matches is the last read.
- R7: After an erase or lock, the engine reads the request address until two consecutive reads return the same bit 6. The number of reads is therefore at least two.
- R8: If POLL_MAX reads are made without success, done is pulsed with err_timeout high. Exactly POLL_MAX reads are made in that case.
- R9: When a program's data poll succeeds, err_verify is set if the final byte read differs from the request data. err_verify is never high together with err_timeout.
- R10: A request is accepted when req_valid and req_ready are both high. req_ready drops the cycle after acceptance and stays low until done pulses. A request offered while busy is ignored. done is high for exactly one cycle, and req_ready returns high in that same cycle.
- R11: Reset sets req_ready high, sets done and both error flags low, sets CE, OE and WE high, and sets the data drive enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle and able to accept |
| req_op | input | 2 | 00 program, 01 erase, 1x boot lock |
| req_addr | input | ADDR_W | Target byte address, also used as the poll address |
| req_data | input | DATA_W | Byte to program |
| done | output | 1 | One-cycle completion pulse |
| err_timeout | output | 1 | Poll budget exhausted; valid with done |
| err_verify | output | 1 | Programmed byte read back differently; valid with done |
| flash_addr | output | ADDR_W | Flash address bus |
| flash_dout | output | DATA_W | Data driven to the flash |
| flash_din | input | DATA_W | Data returned by the flash |
| flash_dq_oe | output | 1 | High while the engine drives the data bus |
| flash_ce_n | output | 1 | Chip enable, active low |
| flash_oe_n | output | 1 | Output enable, active low |
| flash_we_n | output | 1 | Write enable, active low |

## Verification
The bench builds the engine with one setup clock, two strobe clocks, one hold clock and a poll budget of 16. These settings keep each request short, so every busy length in the random mix can be run. They also let directed cases land exactly on the budget edge: a program that completes on read 16 against one that times out, and a toggle run that settles on read 16 against one that does not. A flash model in the bench answers reads with busy-then-final patterns, which exercises both polling styles and the verify mismatch.

// File: rtl/flash_eng_pkg.sv
package flash_eng_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} bus_phase_e;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_WAIT} eng_state_e;
  localparam logic [15:0] UNLK_ADDR_A = 16'h5555;
  localparam logic [15:0] UNLK_ADDR_B = 16'h2AAA;
  localparam logic [7:0]  UNLK_KEY_A  = 8'hAA;
  localparam logic [7:0]  UNLK_KEY_B  = 8'h55;
  localparam logic [7:0]  CMD_PROG    = 8'hA0;
  localparam logic [7:0]  CMD_SETUP6  = 8'h80;
  localparam logic [7:0]  CMD_ERASE   = 8'h10;
  localparam logic [7:0]  CMD_LOCK    = 8'h40;
endpackage

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_eng_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic [1:0]        op,
  input  logic [2:0]        idx,
  input  logic [ADDR_W-1:0] taddr,
  input  logic [DATA_W-1:0] tdata,
  output logic [ADDR_W-1:0] waddr,
  output logic [DATA_W-1:0] wdata,
  output logic              wlast
);
  logic is_prog;
  logic [2:0] last_idx;

  always_comb begin
    is_prog  = (op == 2'b00);
    last_idx = is_prog ? 3'd3 : 3'd5;
    wlast    = (idx == last_idx);
    waddr    = ADDR_W'(UNLK_ADDR_A);
    wdata    = DATA_W'(UNLK_KEY_A);
    case (idx)
      3'd1, 3'd4: begin
        waddr = ADDR_W'(UNLK_ADDR_B);
        wdata = DATA_W'(UNLK_KEY_B);
      end
      3'd2: wdata = is_prog ? DATA_W'(CMD_PROG) : DATA_W'(CMD_SETUP6);
      3'd3: if (is_prog) begin
        waddr = taddr;
        wdata = tdata;
      end
      3'd5: wdata = op[1] ? DATA_W'(CMD_LOCK) : DATA_W'(CMD_ERASE);
      default: ;
    endcase
  end
endmodule

// File: rtl/flash_bus_cycle.sv
module flash_bus_cycle
  import flash_eng_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int SETUP_CLK  = 2,
  parameter int STROBE_CLK = 3,
  parameter int HOLD_CLK   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              is_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] bus_din,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_dq_oe,
  output logic              ce_n,
  output logic              oe_n,
  output logic              we_n,
  output logic [DATA_W-1:0] rdata,
  output logic              cyc_done
);
  localparam int MAX_A = (SETUP_CLK > STROBE_CLK) ? SETUP_CLK : STROBE_CLK;
  localparam int MAX_C = (MAX_A > HOLD_CLK) ? MAX_A : HOLD_CLK;
  localparam int CNT_W = $clog2(MAX_C + 1);

  bus_phase_e       ph;
  logic [CNT_W-1:0] cnt;
  logic             wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= PH_IDLE;
      cnt       <= '0;
      wr_q      <= 1'b0;
      bus_addr  <= '0;
      bus_dout  <= '0;
      bus_dq_oe <= 1'b0;
      ce_n      <= 1'b1;
      oe_n      <= 1'b1;
      we_n      <= 1'b1;
      rdata     <= '0;
      cyc_done  <= 1'b0;
    end else begin
      cyc_done <= 1'b0;
      case (ph)
        PH_IDLE: if (start) begin
          ph        <= PH_SETUP;
          cnt       <= CNT_W'(SETUP_CLK - 1);
          wr_q      <= is_wr;
          bus_addr  <= addr;
          bus_dout  <= wdata;
          bus_dq_oe <= is_wr;
        end
        PH_SETUP: if (cnt == '0) begin
          ph   <= PH_STROBE;
          cnt  <= CNT_W'(STROBE_CLK - 1);
          ce_n <= 1'b0;
          we_n <= ~wr_q;
          oe_n <= wr_q;
        end else cnt <= cnt - 1'b1;
        PH_STROBE: if (cnt == '0) begin
          ph    <= PH_HOLD;
          cnt   <= CNT_W'(HOLD_CLK - 1);
          rdata <= bus_din;
          ce_n  <= 1'b1;
          oe_n  <= 1'b1;
          we_n  <= 1'b1;
        end else cnt <= cnt - 1'b1;
        PH_HOLD: if (cnt == '0) begin
          ph        <= PH_IDLE;
          bus_dq_oe <= 1'b0;
          cyc_done  <= 1'b1;
        end else cnt <= cnt - 1'b1;
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_prog_engine.sv
module flash_prog_engine
  import flash_eng_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int SETUP_CLK  = 2,
  parameter int STROBE_CLK = 3,
  parameter int HOLD_CLK   = 1,
  parameter int POLL_MAX   = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              done,
  output logic              err_timeout,
  output logic              err_verify,
  output logic [ADDR_W-1:0] flash_addr,
  output logic [DATA_W-1:0] flash_dout,
  input  logic [DATA_W-1:0] flash_din,
  output logic              flash_dq_oe,
  output logic              flash_ce_n,
  output logic              flash_oe_n,
  output logic              flash_we_n
);
  localparam int PCNT_W   = $clog2(POLL_MAX + 1);
  localparam int POLL_BIT = DATA_W - 1;
  localparam int TOG_BIT  = DATA_W - 2;

  eng_state_e        st;
  logic [1:0]        op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [2:0]        idx_q;
  logic              polling, have_prev, prev_tog;
  logic [PCNT_W-1:0] poll_cnt;
  logic              cyc_start, cyc_wr, cyc_done;
  logic [ADDR_W-1:0] cyc_addr, seq_addr;
  logic [DATA_W-1:0] cyc_wdata, seq_data, rdata;
  logic              seq_last, poll_hit;

  flash_cmd_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .op(op_q), .idx(idx_q), .taddr(addr_q), .tdata(data_q),
    .waddr(seq_addr), .wdata(seq_data), .wlast(seq_last)
  );

  flash_bus_cycle #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETUP_CLK(SETUP_CLK),
    .STROBE_CLK(STROBE_CLK), .HOLD_CLK(HOLD_CLK)
  ) u_cyc (
    .clk(clk), .rst(rst), .start(cyc_start), .is_wr(cyc_wr),
    .addr(cyc_addr), .wdata(cyc_wdata), .bus_din(flash_din),
    .bus_addr(flash_addr), .bus_dout(flash_dout), .bus_dq_oe(flash_dq_oe),
    .ce_n(flash_ce_n), .oe_n(flash_oe_n), .we_n(flash_we_n),
    .rdata(rdata), .cyc_done(cyc_done)
  );

  always_comb begin
    if (op_q == 2'b00) poll_hit = (rdata[POLL_BIT] == data_q[POLL_BIT]);
    else               poll_hit = have_prev && (rdata[TOG_BIT] == prev_tog);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      req_ready   <= 1'b1;
      done        <= 1'b0;
      err_timeout <= 1'b0;
      err_verify  <= 1'b0;
      op_q        <= '0;
      addr_q      <= '0;
      data_q      <= '0;
      idx_q       <= '0;
      polling     <= 1'b0;
      have_prev   <= 1'b0;
      prev_tog    <= 1'b0;
      poll_cnt    <= '0;
      cyc_start   <= 1'b0;
      cyc_wr      <= 1'b0;
      cyc_addr    <= '0;
      cyc_wdata   <= '0;
    end else begin
      done      <= 1'b0;
      cyc_start <= 1'b0;
      case (st)
        ST_IDLE: if (req_valid && req_ready) begin
          op_q        <= req_op;
          addr_q      <= req_addr;
          data_q      <= req_data;
          idx_q       <= '0;
          polling     <= 1'b0;
          req_ready   <= 1'b0;
          err_timeout <= 1'b0;
          err_verify  <= 1'b0;
          st          <= ST_ISSUE;
        end
        ST_ISSUE: begin
          cyc_start <= 1'b1;
          cyc_wr    <= ~polling;
          cyc_addr  <= polling ? addr_q : seq_addr;
          cyc_wdata <= seq_data;
          st        <= ST_WAIT;
        end
        ST_WAIT: if (cyc_done) begin
          if (!polling) begin
            if (seq_last) begin
              polling   <= 1'b1;
              have_prev <= 1'b0;
              poll_cnt  <= '0;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
            st <= ST_ISSUE;
          end else if (poll_hit) begin
            done       <= 1'b1;
            req_ready  <= 1'b1;
            err_verify <= (op_q == 2'b00) && (rdata != data_q);
            st         <= ST_IDLE;
          end else if (poll_cnt == PCNT_W'(POLL_MAX - 1)) begin
            done        <= 1'b1;
            req_ready   <= 1'b1;
            err_timeout <= 1'b1;
            st          <= ST_IDLE;
          end else begin
            poll_cnt  <= poll_cnt + 1'b1;
            prev_tog  <= rdata[TOG_BIT];
            have_prev <= 1'b1;
            st        <= ST_ISSUE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_prog_engine_chk.sv
module flash_prog_engine_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              done,
  input logic              err_timeout,
  input logic              err_verify,
  input logic [ADDR_W-1:0] flash_addr,
  input logic [DATA_W-1:0] flash_dout,
  input logic              flash_dq_oe,
  input logic              flash_ce_n,
  input logic              flash_oe_n,
  input logic              flash_we_n
);
  AST_WR_LEVELS: assert property (@(posedge clk) disable iff (rst)
    !flash_we_n |-> (!flash_ce_n && flash_oe_n && flash_dq_oe)); // R4
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({~flash_we_n, ~flash_oe_n})); // R4
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!flash_ce_n && $past(!flash_ce_n)) |-> ($stable(flash_addr) && $stable(flash_dout))); // R4
  AST_RD_LEVELS: assert property (@(posedge clk) disable iff (rst)
    !flash_oe_n |-> (!flash_ce_n && flash_we_n && !flash_dq_oe)); // R5
  AST_TIMEOUT_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(err_timeout) |-> done); // R8
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(err_timeout && err_verify)); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready); // R10
  AST_READY_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(req_ready) |-> done); // R10
endmodule

bind flash_prog_engine flash_prog_engine_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .err_timeout(err_timeout), .err_verify(err_verify),
  .flash_addr(flash_addr), .flash_dout(flash_dout), .flash_dq_oe(flash_dq_oe),
  .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n), .flash_we_n(flash_we_n)
);

// File: tb/test_flash_prog_engine.sv
module test_flash_prog_engine;
  localparam int PM = 16;
  localparam int STRB = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_op = '0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_data = '0;
  logic done, err_timeout, err_verify;
  logic [15:0] flash_addr;
  logic [7:0] flash_dout, flash_din;
  logic flash_dq_oe, flash_ce_n, flash_oe_n, flash_we_n;

  int nchk = 0, nfail = 0;

  always #4 clk = ~clk;

  flash_prog_engine #(.ADDR_W(16), .DATA_W(8), .SETUP_CLK(1), .STROBE_CLK(STRB),
                      .HOLD_CLK(1), .POLL_MAX(PM)) i_flash_prog_engine (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .done(done),
    .err_timeout(err_timeout), .err_verify(err_verify), .flash_addr(flash_addr),
    .flash_dout(flash_dout), .flash_din(flash_din), .flash_dq_oe(flash_dq_oe),
    .flash_ce_n(flash_ce_n), .flash_oe_n(flash_oe_n), .flash_we_n(flash_we_n)
  );

  // flash model
  int m_toggle = 0, m_busy = 0;
  logic [7:0] m_data = '0, m_final = '0;
  logic [15:0] m_addr = '0;
  int wr_base = 0, rd_base = 0;
  int wr_count = 0, rd_count = 0, we_len = 0, bad_strobe = 0, bad_rdaddr = 0;
  logic [15:0] wa [0:7];
  logic [7:0]  wd [0:7];
  logic prev_we = 1'b1, prev_oe = 1'b1;

  always_comb begin
    int k;
    logic b6;
    k = rd_count - rd_base;
    b6 = (k < m_busy) ? k[0] : m_busy[0];
    if (m_toggle != 0) flash_din = {1'b1, b6, 6'h3F};
    else if (k < m_busy) flash_din = {~m_data[7], 7'h00};
    else flash_din = m_final;
  end

  always @(posedge clk) begin
    prev_we <= flash_we_n;
    prev_oe <= flash_oe_n;
    if (!flash_we_n) we_len <= we_len + 1;
    if (flash_we_n && !prev_we) begin
      if (wr_count - wr_base < 8) begin
        wa[wr_count - wr_base] <= flash_addr;
        wd[wr_count - wr_base] <= flash_dout;
      end
      if (we_len != STRB) bad_strobe <= bad_strobe + 1;
      we_len <= 0;
      wr_count <= wr_count + 1;
    end
    if (flash_oe_n && !prev_oe) begin
      if (flash_addr != m_addr) bad_rdaddr <= bad_rdaddr + 1;
      rd_count <= rd_count + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  endtask

  function automatic logic [15:0] e_addr(input logic [1:0] op, input int i, input logic [15:0] ta);
    if (op == 2'b00 && i == 3) return ta;
    if (i == 1 || i == 4) return 16'h2AAA;
    return 16'h5555;
  endfunction

  function automatic logic [7:0] e_data(input logic [1:0] op, input int i, input logic [7:0] d);
    case (i)
      0, 3: return (op == 2'b00 && i == 3) ? d : 8'hAA;
      1, 4: return 8'h55;
      2: return (op == 2'b00) ? 8'hA0 : 8'h80;
      default: return op[1] ? 8'h40 : 8'h10;
    endcase
  endfunction

  task automatic run_req(input logic [1:0] op, input logic [15:0] a, input logic [7:0] d,
                         input int busy, input logic [7:0] fin, input bit poke);
    int nwr, exp_rd, rds, bs0, ba0;
    bit ok_succ, exp_to, exp_vf;
    string wtag;
    @(negedge clk);
    m_toggle = (op != 2'b00) ? 1 : 0;
    m_busy = busy; m_data = d; m_final = fin; m_addr = a;
    wr_base = wr_count; rd_base = rd_count;
    bs0 = bad_strobe; ba0 = bad_rdaddr;
    req_op = op; req_addr = a; req_data = d; req_valid = 1'b1;
    chk(req_ready == 1'b1, "R10 ready idle", int'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R10 ready drops", int'(req_ready), 0);
    if (poke) begin
      req_valid = 1'b1; req_op = ~op; req_addr = ~a; req_data = ~d;
      repeat (5) @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, "R10 busy refuses", int'(req_ready), 0);
    end
    for (int c = 0; c < 3000 && !done; c++) @(negedge clk);
    chk(done == 1'b1, "R10 done seen", int'(done), 1);
    nwr = (op == 2'b00) ? 4 : 6;
    if (op == 2'b00) begin
      ok_succ = (fin[7] == d[7]) && (busy + 1 <= PM);
      exp_rd = ok_succ ? busy + 1 : PM;
      exp_vf = ok_succ && (fin != d);
    end else begin
      ok_succ = (busy + 2 <= PM);
      exp_rd = ok_succ ? busy + 2 : PM;
      exp_vf = 1'b0;
    end
    exp_to = !ok_succ;
    chk(req_ready == 1'b1, "R10 ready with done", int'(req_ready), 1);
    chk(err_timeout == exp_to, "R8 timeout flag", int'(err_timeout), int'(exp_to));
    chk(err_verify == exp_vf, "R9 verify flag", int'(err_verify), int'(exp_vf));
    rds = rd_count - rd_base;
    chk(rds == exp_rd, op == 2'b00 ? "R6 data poll reads" : "R7 toggle poll reads", rds, exp_rd);
    chk(wr_count - wr_base == nwr, "R1 R2 R3 write count", wr_count - wr_base, nwr);
    wtag = (op == 2'b00) ? "R1 write" : (op == 2'b01 ? "R2 write" : "R3 write");
    for (int i = 0; i < nwr && i < 8; i++) begin
      chk(wa[i] == e_addr(op, i, a), {wtag, " addr"}, int'(wa[i]), int'(e_addr(op, i, a)));
      chk(wd[i] == e_data(op, i, d), {wtag, " data"}, int'(wd[i]), int'(e_data(op, i, d)));
    end
    chk(bad_strobe == bs0, "R4 strobe length", bad_strobe - bs0, 0);
    chk(bad_rdaddr == ba0, "R5 read address", bad_rdaddr - ba0, 0);
    @(negedge clk);
    chk(done == 1'b0, "R10 done one cycle", int'(done), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    logic [1:0] op;
    logic [7:0] d, fin;
    void'($urandom(32'd20240));
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R11 ready", int'(req_ready), 1);
    chk(done == 1'b0 && err_timeout == 1'b0 && err_verify == 1'b0, "R11 flags",
        int'({done, err_timeout, err_verify}), 0);
    chk(flash_ce_n && flash_oe_n && flash_we_n && !flash_dq_oe, "R11 bus idle",
        int'({flash_ce_n, flash_oe_n, flash_we_n, flash_dq_oe}), 4'b1110);
    rst = 1'b0;
    // directed corners
    run_req(2'b00, 16'h3456, 8'h5A, 0, 8'h5A, 1'b1);   // R6 immediate
    run_req(2'b00, 16'h8001, 8'hC3, PM - 1, 8'hC3, 1'b0); // R8 last-read success
    run_req(2'b00, 16'h8002, 8'hC3, PM, 8'hC3, 1'b0);   // R8 timeout
    run_req(2'b00, 16'h0100, 8'h81, 0, 8'h01, 1'b0);    // R8 bit7 never matches
    run_req(2'b00, 16'h0200, 8'h7E, 3, 8'h7C, 1'b0);    // R9 verify fail
    run_req(2'b01, 16'h0000, 8'h00, 0, 8'h00, 1'b1);    // R7 minimum two reads
    run_req(2'b01, 16'h1234, 8'h00, PM - 2, 8'h00, 1'b0); // R7 settles on last read
    run_req(2'b10, 16'h1FFF, 8'h00, PM - 1, 8'h00, 1'b0); // R3 lock timeout
    run_req(2'b11, 16'h0002, 8'h00, 5, 8'h00, 1'b1);    // R3 alternate code
    // random mix
    for (int n = 0; n < 30; n++) begin
      op = 2'($urandom % 4);
      d = 8'($urandom);
      fin = d;
      if ($urandom % 4 == 0) fin = d ^ {1'b0, 7'($urandom % 127 + 1)};
      run_req(op, 16'($urandom), d, int'($urandom % 20), fin, ($urandom % 3) == 0);
    end
    summary();
  end
endmodule